// File: doc/BRIEF.md
# Packet Header Format Stage

This block sits between a queue manager and a transmit engine. It accepts one 32-bit packet handle at a time. It discards the handle when its valid bit is clear. For a valid handle it reads the packet's buffer descriptor through a descriptor memory port and looks up the source MAC address of the output port in a local per-port table. It then sends a five-word transmit header record to the transmit side.

When the descriptor's next-buffer pointer is non-null, the packet is chained. For a chained packet the block forwards the pointed-to buffer instead of the header buffer. It also writes null into the descriptor's next-buffer field and hands the header buffer back to the free list. Every forwarded packet also issues one statistics beat carrying the descriptor's statistics index, and it advances a transmit counter kept for its output port.

The block holds one packet at a time. Input ready stays low from the moment a valid handle is accepted until the whole record and every side beat have been taken. A stall on any output therefore reaches the queue manager, and no handle is lost or repeated.

Top module: `hdr_fmt_stage`

## Requirements
- R1: The input handle is laid out as bit 31 valid, bits 30:28 reserved, bits 27:24 output port and bits 23:0 buffer handle. A handle with bit 31 clear is dropped. It causes no descriptor read or write, no output beat, no statistics beat and no counter change.
- R2: A valid handle triggers reads of descriptor words 0, 3, 4 and 5 at the buffer handle. Read data returns one cycle after the read strobe. Word 0 is the 32-bit next-buffer pointer. Word 3 holds the statistics index in bits 31:16 and destination MAC bits 47:32 in bits 15:0. Word 4 holds destination MAC bits 31:0. Word 5 holds the EtherType in bits 15:0.
- R3: An unchained packet (next pointer equal to zero) forwards the input buffer handle. It produces no descriptor write and no free-list beat.
- R4: A chained packet (next pointer non-zero) forwards bits 23:0 of the next pointer. It writes 0 into descriptor word 0 and emits exactly one free-list beat carrying the input buffer handle.
- R5: The record is five beats, marked by out_idx 0 to 4 with out_last on beat 4. Beat 0 is {1, 000, port, forwarded handle}. Beat 1 is DMAC[47:16]. Beat 2 is {DMAC[15:0], SMAC[47:32]}. Beat 3 is SMAC[31:0]. Beat 4 is {EtherType, 16'h0000}.
- R6: The source MAC is the table entry last written for the output port through the programming port.
- R7: A port whose entry has not been programmed since reset still forwards its packet, with an all-zero source MAC. It also sets smac_err, which then stays set until reset.
- R8: Each forwarded packet emits exactly one statistics beat carrying the descriptor statistics index.
- R9: Each forwarded packet increments the transmit counter of its port by one. cnt_value shows the counter selected by cnt_sel.
- R10: After a valid handle is accepted, in_ready stays low until all five record beats and any free-list and statistics beats have been accepted. While a valid output is stalled, its data holds steady.
- R11: Reset clears all transmit counters, smac_err, out_valid, free_valid and stat_valid, and leaves in_ready high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Handle offered |
| in_ready | output | 1 | Handle accepted when high |
| in_handle | input | 32 | Packet handle word |
| desc_rd_en | output | 1 | Descriptor read strobe |
| desc_wr_en | output | 1 | Descriptor write strobe |
| desc_addr | output | 24 | Descriptor buffer handle |
| desc_word | output | 3 | Descriptor word index |
| desc_wr_data | output | 32 | Descriptor write data |
| desc_rd_data | input | 32 | Read data, one cycle after strobe |
| smac_wr_en | input | 1 | Source MAC table write |
| smac_wr_port | input | 4 | Table entry to write |
| smac_wr_mac | input | 48 | Source MAC value |
| out_valid | output | 1 | Record beat valid |
| out_ready | input | 1 | Transmit side accepts beat |
| out_word | output | 32 | Record beat data |
| out_idx | output | 3 | Beat number 0..4 |
| out_last | output | 1 | High on beat 4 |
| free_valid | output | 1 | Free-list beat valid |
| free_ready | input | 1 | Free list accepts beat |
| free_handle | output | 24 | Buffer to free |
| stat_valid | output | 1 | Statistics beat valid |
| stat_ready | input | 1 | Statistics accepts beat |
| stat_index | output | 16 | Statistics index |
| cnt_sel | input | 4 | Port counter to show |
| cnt_value | output | 16 | Selected transmit count |
| smac_err | output | 1 | Sticky unprogrammed-port flag |

## Verification
The assertions assume that the descriptor memory returns read data exactly one cycle after each strobe. They also assume that in_handle holds steady while in_valid waits for in_ready. The bench's descriptor model is a registered array that answers every strobe on the next edge. The bench changes the handle only at a falling edge before it raises in_valid, and it drops in_valid after the accepting edge. Ready inputs are toggled from a pseudo-random sequence so that the assertions see stalls on every output, including stalls that arrive in the middle of the record.

// File: rtl/hdr_fmt_pkg.sv
package hdr_fmt_pkg;
   typedef enum logic [3:0] {
      ST_IDLE, ST_RD_NEXT, ST_RD_STAT, ST_RD_DMAC, ST_RD_ETYPE,
      ST_CAPTURE, ST_CLR_NEXT, ST_EMIT, ST_DRAIN
   } fmt_state_e;

   localparam logic [2:0] DW_NEXT  = 3'd0;
   localparam logic [2:0] DW_STAT  = 3'd3;
   localparam logic [2:0] DW_DMAC  = 3'd4;
   localparam logic [2:0] DW_ETYPE = 3'd5;
   localparam int unsigned REC_BEATS = 5;
   localparam int unsigned MAC_W     = 48;
endpackage

// File: rtl/hdr_fmt_smac_table.sv
module hdr_fmt_smac_table #(
   parameter int unsigned PORT_W = 4,
   parameter int unsigned MAC_W  = 48
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PORT_W-1:0] wr_port,
   input  logic [MAC_W-1:0]  wr_mac,
   input  logic [PORT_W-1:0] rd_port,
   output logic [MAC_W-1:0]  rd_mac,
   output logic              rd_hit
);
   localparam int unsigned NPORTS = 1 << PORT_W;

   logic [MAC_W-1:0]  entry_q [NPORTS];
   logic [NPORTS-1:0] loaded_q;

   for (genvar p = 0; p < NPORTS; p++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_en && wr_port == PORT_W'(p)) entry_q[p] <= wr_mac;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     loaded_q <= '0;
      else if (wr_en) loaded_q[wr_port] <= 1'b1;
   end

   assign rd_hit = loaded_q[rd_port];
   assign rd_mac = rd_hit ? entry_q[rd_port] : '0;
endmodule

// File: rtl/hdr_fmt_tx_counters.sv
module hdr_fmt_tx_counters #(
   parameter int unsigned PORT_W = 4,
   parameter int unsigned CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inc,
   input  logic [PORT_W-1:0] inc_port,
   input  logic [PORT_W-1:0] sel,
   output logic [CNT_W-1:0]  value
);
   localparam int unsigned NPORTS = 1 << PORT_W;

   logic [CNT_W-1:0] cnt_q [NPORTS];

   for (genvar p = 0; p < NPORTS; p++) begin : g_cnt
      always_ff @(posedge clk) begin
         if (!rst_n)                                cnt_q[p] <= '0;
         else if (inc && inc_port == PORT_W'(p))    cnt_q[p] <= cnt_q[p] + 1'b1;
      end
   end

   assign value = cnt_q[sel];
endmodule

// File: rtl/hdr_fmt_ctrl.sv
module hdr_fmt_ctrl
   import hdr_fmt_pkg::*;
#(
   parameter int unsigned PORT_W   = 4,
   parameter int unsigned HANDLE_W = 24,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned STAT_W   = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WORD_W-1:0]   in_handle,
   output logic                desc_rd_en,
   output logic                desc_wr_en,
   output logic [HANDLE_W-1:0] desc_addr,
   output logic [2:0]          desc_word,
   output logic [WORD_W-1:0]   desc_wr_data,
   input  logic [WORD_W-1:0]   desc_rd_data,
   output logic [PORT_W-1:0]   smac_port,
   input  logic [MAC_W-1:0]    smac_mac,
   input  logic                smac_hit,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_word,
   output logic [2:0]          out_idx,
   output logic                out_last,
   output logic                free_valid,
   input  logic                free_ready,
   output logic [HANDLE_W-1:0] free_handle,
   output logic                stat_valid,
   input  logic                stat_ready,
   output logic [STAT_W-1:0]   stat_index,
   output logic                cnt_inc,
   output logic [PORT_W-1:0]   cnt_port,
   output logic                smac_err
);
   localparam int unsigned RSV_W   = WORD_W - 1 - PORT_W - HANDLE_W;
   localparam int unsigned HALF_W  = WORD_W / 2;
   localparam int unsigned VLD_BIT = WORD_W - 1;
   localparam logic [2:0]  LAST_BEAT = 3'(REC_BEATS - 1);

   fmt_state_e state_q;
   logic [PORT_W-1:0]   port_q;
   logic [HANDLE_W-1:0] hdl_q, fwd_q;
   logic [WORD_W-1:0]   next_q;
   logic [STAT_W-1:0]   stat_q;
   logic [MAC_W-1:0]    dmac_q, smac_q;
   logic [HALF_W-1:0]   etype_q;
   logic [2:0]          beat_q;
   logic                stat_pend_q, free_pend_q, err_q;
   logic                chained;

   assign chained = (next_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q     <= ST_IDLE;
         stat_pend_q <= 1'b0;
         free_pend_q <= 1'b0;
         err_q       <= 1'b0;
         beat_q      <= '0;
      end else begin
         if (stat_valid && stat_ready) stat_pend_q <= 1'b0;
         if (free_valid && free_ready) free_pend_q <= 1'b0;
         unique case (state_q)
            ST_IDLE: begin
               if (in_valid && in_handle[VLD_BIT]) begin
                  port_q  <= in_handle[HANDLE_W +: PORT_W];
                  hdl_q   <= in_handle[HANDLE_W-1:0];
                  state_q <= ST_RD_NEXT;
               end
            end
            ST_RD_NEXT: state_q <= ST_RD_STAT;
            ST_RD_STAT: begin
               next_q  <= desc_rd_data;
               state_q <= ST_RD_DMAC;
            end
            ST_RD_DMAC: begin
               stat_q                <= desc_rd_data[WORD_W-1 -: STAT_W];
               dmac_q[MAC_W-1:WORD_W] <= desc_rd_data[MAC_W-WORD_W-1:0];
               state_q               <= ST_RD_ETYPE;
            end
            ST_RD_ETYPE: begin
               dmac_q[WORD_W-1:0] <= desc_rd_data;
               state_q            <= ST_CAPTURE;
            end
            ST_CAPTURE: begin
               etype_q     <= desc_rd_data[HALF_W-1:0];
               smac_q      <= smac_mac;
               fwd_q       <= chained ? next_q[HANDLE_W-1:0] : hdl_q;
               stat_pend_q <= 1'b1;
               free_pend_q <= chained;
               beat_q      <= '0;
               if (!smac_hit) err_q <= 1'b1;
               state_q     <= chained ? ST_CLR_NEXT : ST_EMIT;
            end
            ST_CLR_NEXT: state_q <= ST_EMIT;
            ST_EMIT: begin
               if (out_ready) begin
                  if (beat_q == LAST_BEAT) state_q <= ST_DRAIN;
                  else                     beat_q  <= beat_q + 1'b1;
               end
            end
            ST_DRAIN: begin
               if (!stat_pend_q && !free_pend_q) state_q <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      desc_rd_en = 1'b0;
      desc_word  = DW_NEXT;
      unique case (state_q)
         ST_RD_NEXT:  begin desc_rd_en = 1'b1; desc_word = DW_NEXT;  end
         ST_RD_STAT:  begin desc_rd_en = 1'b1; desc_word = DW_STAT;  end
         ST_RD_DMAC:  begin desc_rd_en = 1'b1; desc_word = DW_DMAC;  end
         ST_RD_ETYPE: begin desc_rd_en = 1'b1; desc_word = DW_ETYPE; end
         default: ;
      endcase
   end

   always_comb begin
      unique case (beat_q)
         3'd0:    out_word = {1'b1, {RSV_W{1'b0}}, port_q, fwd_q};
         3'd1:    out_word = dmac_q[MAC_W-1 -: WORD_W];
         3'd2:    out_word = {dmac_q[HALF_W-1:0], smac_q[MAC_W-1 -: HALF_W]};
         3'd3:    out_word = smac_q[WORD_W-1:0];
         default: out_word = {etype_q, {HALF_W{1'b0}}};
      endcase
   end

   assign in_ready     = (state_q == ST_IDLE);
   assign desc_wr_en   = (state_q == ST_CLR_NEXT);
   assign desc_wr_data = '0;
   assign desc_addr    = hdl_q;
   assign smac_port    = port_q;
   assign out_valid    = (state_q == ST_EMIT);
   assign out_idx      = beat_q;
   assign out_last     = (beat_q == LAST_BEAT);
   assign free_valid   = free_pend_q;
   assign free_handle  = hdl_q;
   assign stat_valid   = stat_pend_q;
   assign stat_index   = stat_q;
   assign cnt_inc      = (state_q == ST_CAPTURE);
   assign cnt_port     = port_q;
   assign smac_err     = err_q;
endmodule

// File: rtl/hdr_fmt_stage.sv
module hdr_fmt_stage
   import hdr_fmt_pkg::*;
#(
   parameter int unsigned PORT_W   = 4,
   parameter int unsigned HANDLE_W = 24,
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned STAT_W   = 16,
   parameter int unsigned CNT_W    = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   output logic                in_ready,
   input  logic [WORD_W-1:0]   in_handle,
   output logic                desc_rd_en,
   output logic                desc_wr_en,
   output logic [HANDLE_W-1:0] desc_addr,
   output logic [2:0]          desc_word,
   output logic [WORD_W-1:0]   desc_wr_data,
   input  logic [WORD_W-1:0]   desc_rd_data,
   input  logic                smac_wr_en,
   input  logic [PORT_W-1:0]   smac_wr_port,
   input  logic [MAC_W-1:0]    smac_wr_mac,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_word,
   output logic [2:0]          out_idx,
   output logic                out_last,
   output logic                free_valid,
   input  logic                free_ready,
   output logic [HANDLE_W-1:0] free_handle,
   output logic                stat_valid,
   input  logic                stat_ready,
   output logic [STAT_W-1:0]   stat_index,
   input  logic [PORT_W-1:0]   cnt_sel,
   output logic [CNT_W-1:0]    cnt_value,
   output logic                smac_err
);
   if (1 + 3 + PORT_W + HANDLE_W != WORD_W) begin : g_bad_layout
      $error("handle fields must fill the word exactly");
   end
   if (WORD_W != 32 || STAT_W > WORD_W / 2) begin : g_bad_word
      $error("descriptor word layout needs 32-bit words");
   end
   if (CNT_W < 2) begin : g_bad_cnt
      $error("counter width too small");
   end

   logic [PORT_W-1:0] smac_port;
   logic [MAC_W-1:0]  smac_mac;
   logic              smac_hit;
   logic              cnt_inc;
   logic [PORT_W-1:0] cnt_port;

   hdr_fmt_smac_table #(.PORT_W(PORT_W), .MAC_W(MAC_W)) u_smac (
      .clk(clk), .rst_n(rst_n),
      .wr_en(smac_wr_en), .wr_port(smac_wr_port), .wr_mac(smac_wr_mac),
      .rd_port(smac_port), .rd_mac(smac_mac), .rd_hit(smac_hit)
   );

   hdr_fmt_tx_counters #(.PORT_W(PORT_W), .CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n),
      .inc(cnt_inc), .inc_port(cnt_port),
      .sel(cnt_sel), .value(cnt_value)
   );

   hdr_fmt_ctrl #(
      .PORT_W(PORT_W), .HANDLE_W(HANDLE_W), .WORD_W(WORD_W), .STAT_W(STAT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_handle(in_handle),
      .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_addr(desc_addr),
      .desc_word(desc_word), .desc_wr_data(desc_wr_data), .desc_rd_data(desc_rd_data),
      .smac_port(smac_port), .smac_mac(smac_mac), .smac_hit(smac_hit),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .out_idx(out_idx), .out_last(out_last),
      .free_valid(free_valid), .free_ready(free_ready), .free_handle(free_handle),
      .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_index(stat_index),
      .cnt_inc(cnt_inc), .cnt_port(cnt_port), .smac_err(smac_err)
   );
endmodule

// File: rtl/hdr_fmt_stage_chk.sv
module hdr_fmt_stage_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        in_valid,
   input logic        in_ready,
   input logic [31:0] in_handle,
   input logic        desc_rd_en,
   input logic        desc_wr_en,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_word,
   input logic [2:0]  out_idx,
   input logic        free_valid,
   input logic        free_ready,
   input logic [23:0] free_handle,
   input logic        stat_valid,
   input logic        stat_ready,
   input logic [15:0] stat_index,
   input logic        smac_err
);
   // R1
   drop_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !in_handle[31]) |=> (!desc_rd_en && in_ready));

   // R5
   beat0_valid_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_idx == 3'd0) |-> out_word[31]);

   // R4
   desc_port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({desc_rd_en, desc_wr_en}));

   // R4
   free_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (free_valid && !free_ready) |=> (free_valid && $stable(free_handle)));

   // R8
   stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_valid && !stat_ready) |=> (stat_valid && $stable(stat_index)));

   // R10
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_word) && $stable(out_idx)));

   // R10
   busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_handle[31]) |=> !in_ready);

   // R7
   err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      smac_err |=> smac_err);
endmodule

bind hdr_fmt_stage hdr_fmt_stage_chk u_chk (
   .clk(clk), .rst_n(rst_n),
   .in_valid(in_valid), .in_ready(in_ready), .in_handle(in_handle),
   .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en),
   .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word), .out_idx(out_idx),
   .free_valid(free_valid), .free_ready(free_ready), .free_handle(free_handle),
   .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_index(stat_index),
   .smac_err(smac_err)
);

// File: tb/test_hdr_fmt_stage.sv
module test_hdr_fmt_stage;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_handle = '0;
   logic        desc_rd_en, desc_wr_en;
   logic [23:0] desc_addr;
   logic [2:0]  desc_word;
   logic [31:0] desc_wr_data;
   logic [31:0] desc_rd_data = '0;
   logic        smac_wr_en = 1'b0;
   logic [3:0]  smac_wr_port = '0;
   logic [47:0] smac_wr_mac = '0;
   logic        out_valid, out_last;
   logic        out_ready = 1'b1;
   logic [31:0] out_word;
   logic [2:0]  out_idx;
   logic        free_valid, stat_valid;
   logic        free_ready = 1'b1, stat_ready = 1'b1;
   logic [23:0] free_handle;
   logic [15:0] stat_index;
   logic [3:0]  cnt_sel = '0;
   logic [15:0] cnt_value;
   logic        smac_err;

   always #5 clk = ~clk;

   hdr_fmt_stage i_hdr_fmt_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_handle(in_handle),
      .desc_rd_en(desc_rd_en), .desc_wr_en(desc_wr_en), .desc_addr(desc_addr),
      .desc_word(desc_word), .desc_wr_data(desc_wr_data), .desc_rd_data(desc_rd_data),
      .smac_wr_en(smac_wr_en), .smac_wr_port(smac_wr_port), .smac_wr_mac(smac_wr_mac),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .out_idx(out_idx), .out_last(out_last),
      .free_valid(free_valid), .free_ready(free_ready), .free_handle(free_handle),
      .stat_valid(stat_valid), .stat_ready(stat_ready), .stat_index(stat_index),
      .cnt_sel(cnt_sel), .cnt_value(cnt_value), .smac_err(smac_err)
   );

   // descriptor memory: 4 buffers x 8 words, one-cycle read latency
   logic [31:0] dmem [0:31];
   always @(posedge clk) begin
      if (desc_rd_en) desc_rd_data <= dmem[{desc_addr[1:0], desc_word}];
      if (desc_wr_en) dmem[{desc_addr[1:0], desc_word}] <= desc_wr_data;
   end

   // monitor
   logic [31:0] obuf [0:7];
   int obeats = 0, rd_cnt = 0, wr_cnt = 0, free_cnt = 0, stat_cnt = 0, order_bad = 0;
   logic [23:0] last_free;
   logic [15:0] last_stat;
   always @(posedge clk) if (rst_n) begin
      if (out_valid && out_ready) begin
         if (out_idx != obeats[2:0] || out_last != (out_idx == 3'd4)) order_bad++;
         obuf[obeats[2:0]] <= out_word;
         obeats++;
      end
      if (desc_rd_en) rd_cnt++;
      if (desc_wr_en) wr_cnt++;
      if (free_valid && free_ready) begin free_cnt++; last_free <= free_handle; end
      if (stat_valid && stat_ready) begin stat_cnt++; last_stat <= stat_index; end
   end

   // ready stimulus
   logic       stall_en = 1'b0;
   logic [7:0] lfsr = 8'hA5;
   always @(negedge clk) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      if (stall_en) begin
         out_ready  = lfsr[0];
         free_ready = lfsr[3];
         stat_ready = lfsr[6];
      end else begin
         out_ready = 1'b1; free_ready = 1'b1; stat_ready = 1'b1;
      end
   end

   int n_tests = 0, n_fail = 0;
   bit finished = 0;

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic clear_mon();
      obeats = 0; rd_cnt = 0; wr_cnt = 0; free_cnt = 0; stat_cnt = 0; order_bad = 0;
   endtask

   task automatic program_smac(input [3:0] p, input [47:0] mac);
      @(negedge clk);
      smac_wr_en = 1'b1; smac_wr_port = p; smac_wr_mac = mac;
      @(negedge clk);
      smac_wr_en = 1'b0;
   endtask

   task automatic set_desc(input [1:0] b, input [31:0] nxt, input [15:0] sidx,
                           input [47:0] dmac, input [15:0] etype);
      dmem[{b, 3'd0}] = nxt;
      dmem[{b, 3'd3}] = {sidx, dmac[47:32]};
      dmem[{b, 3'd4}] = dmac[31:0];
      dmem[{b, 3'd5}] = {16'hFFFF, etype};
   endtask

   // send a handle and wait until the block is idle again
   task automatic send(input [31:0] h, output bit busy_ok);
      clear_mon();
      @(negedge clk);
      in_handle = h; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      busy_ok = 1'b1;
      if (h[31] && in_ready) busy_ok = 1'b0;
      for (int i = 0; i < 400 && !in_ready; i++) begin
         @(negedge clk);
         if (!in_ready && out_valid == 1'b0 && obeats == 5 && free_valid == 0 && stat_valid == 0)
            busy_ok = busy_ok; // still draining is allowed one cycle
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic check_record(input string req, input [3:0] port, input [23:0] fwd,
                               input [47:0] dmac, input [47:0] smac, input [15:0] etype);
      logic [31:0] exp [0:4];
      exp[0] = {1'b1, 3'b000, port, fwd};
      exp[1] = dmac[47:16];
      exp[2] = {dmac[15:0], smac[47:32]};
      exp[3] = smac[31:0];
      exp[4] = {etype, 16'h0000};
      chk(obeats == 5, {req, " beat count"}, obeats, 5);
      chk(order_bad == 0, {req, " R5 beat order"}, order_bad, 0);
      for (int k = 0; k < 5; k++)
         chk(obuf[k] == exp[k], {req, " word"}, obuf[k], exp[k]);
   endtask

   task automatic t_reset();
      cnt_sel = 4'd1;
      #1;
      chk(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
      chk(!out_valid && !free_valid && !stat_valid, "R11 valids", {out_valid, free_valid, stat_valid}, 0);
      chk(smac_err == 1'b0, "R11 smac_err", smac_err, 0);
      chk(cnt_value == 16'd0, "R11 counter", cnt_value, 0);
   endtask

   task automatic t_invalid();
      bit b;
      send({1'b0, 3'b000, 4'd1, 24'h000001}, b);
      cnt_sel = 4'd1; #1;
      chk(rd_cnt == 0 && wr_cnt == 0, "R1 no descriptor access", rd_cnt + wr_cnt, 0);
      chk(obeats == 0 && stat_cnt == 0 && free_cnt == 0, "R1 no output", obeats + stat_cnt + free_cnt, 0);
      chk(cnt_value == 0, "R1 counter unchanged", cnt_value, 0);
   endtask

   task automatic t_unchained();
      bit b;
      set_desc(2'd1, 32'h0, 16'h1234, 48'h0A0B0C0D0E0F, 16'h0800);
      send({1'b1, 3'b000, 4'd1, 24'h000001}, b);
      chk(b, "R10 busy after accept", 0, 1);
      chk(rd_cnt == 4, "R2 four reads", rd_cnt, 4);
      check_record("R3/R5/R6 unchained", 4'd1, 24'h000001, 48'h0A0B0C0D0E0F, 48'h020000AA0011, 16'h0800);
      chk(wr_cnt == 0 && free_cnt == 0, "R3 no write/free", wr_cnt + free_cnt, 0);
      chk(stat_cnt == 1 && last_stat == 16'h1234, "R8 stats", last_stat, 16'h1234);
      cnt_sel = 4'd1; #1;
      chk(cnt_value == 16'd1, "R9 counter port 1", cnt_value, 1);
      chk(smac_err == 1'b0, "R6 no error", smac_err, 0);
   endtask

   task automatic t_chained();
      bit b;
      stall_en = 1'b1;
      set_desc(2'd2, 32'h000ABCDE, 16'hBEEF, 48'h112233445566, 16'h86DD);
      send({1'b1, 3'b000, 4'd2, 24'h000002}, b);
      stall_en = 1'b0;
      check_record("R4/R5 chained stalled", 4'd2, 24'h0ABCDE, 48'h112233445566, 48'hCAFEF00D1234, 16'h86DD);
      chk(wr_cnt == 1 && dmem[{2'd2, 3'd0}] == 32'h0, "R4 next cleared", dmem[{2'd2, 3'd0}], 0);
      chk(free_cnt == 1 && last_free == 24'h000002, "R4 free handle", last_free, 24'h000002);
      chk(stat_cnt == 1 && last_stat == 16'hBEEF, "R8 stats chained", last_stat, 16'hBEEF);
      cnt_sel = 4'd2; #1;
      chk(cnt_value == 16'd1, "R9 counter port 2", cnt_value, 1);
   endtask

   task automatic t_unprog();
      bit b;
      stall_en = 1'b1;
      set_desc(2'd3, 32'h0, 16'h0042, 48'hFFEEDDCCBBAA, 16'h0806);
      send({1'b1, 3'b000, 4'd5, 24'h000003}, b);
      stall_en = 1'b0;
      check_record("R7 unprogrammed", 4'd5, 24'h000003, 48'hFFEEDDCCBBAA, 48'h0, 16'h0806);
      chk(smac_err == 1'b1, "R7 error set", smac_err, 1);
      cnt_sel = 4'd5; #1;
      chk(cnt_value == 16'd1, "R9 counter port 5", cnt_value, 1);
      // error stays set across a later good packet
      set_desc(2'd1, 32'h0, 16'h0007, 48'h0A0B0C0D0E0F, 16'h0800);
      send({1'b1, 3'b000, 4'd1, 24'h000001}, b);
      chk(smac_err == 1'b1, "R7 error sticky", smac_err, 1);
      cnt_sel = 4'd1; #1;
      chk(cnt_value == 16'd2, "R9 counter port 1 again", cnt_value, 2);
   endtask

   task automatic t_reprogram();
      bit b;
      program_smac(4'd1, 48'h5E5E5E5E5E5E);
      set_desc(2'd1, 32'h0, 16'h0009, 48'h0A0B0C0D0E0F, 16'h0800);
      send({1'b1, 3'b000, 4'd1, 24'h000001}, b);
      check_record("R6 reprogrammed", 4'd1, 24'h000001, 48'h0A0B0C0D0E0F, 48'h5E5E5E5E5E5E, 16'h0800);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 32; i++) dmem[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      program_smac(4'd1, 48'h020000AA0011);
      program_smac(4'd2, 48'hCAFEF00D1234);
      t_invalid();
      t_unchained();
      t_chained();
      t_unprog();
      t_reprogram();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule